// File: doc/BRIEF.md
# Matrix Keyboard Level Interrupt Controller

This block watches eight port input lines that serve as the rows or columns of a key matrix. Each line passes through a two-stage synchronizer and is compared against its own polarity bit. When a line sits at its chosen active level, a sticky per-line flag is set. The flags are masked by a per-line enable byte and gated by one global enable bit to form a single registered interrupt request.

A separate wake output is built without any clock from the raw pins, the polarity bits and the enable bits. It can therefore pull the device out of idle or power-down while the clock is stopped. Lines whose enable bit is clear never reach the request or the wake output, so they stay free for use as ordinary inputs. Any mix of one to eight keyboard lines is supported.

Software reaches the block through a small register bus with a write strobe, a two-bit address and registered read data.

Top module: `kbd_level_irq`

## Requirements
- R1: After a synchronous reset, the polarity, enable, flag and control registers are all 0, the request is 0 and the read data is 0. The synchronizer stages reset to 1.
- R2: Polarity bit i = 0 makes line i active low, and 1 makes it active high. A line held at its active level sets flag bit i at the third rising clock edge after the pin settles.
- R3: Flag bits are set whether or not their enable bit is set.
- R4: Writing address 2 (flags) clears each flag bit whose written data bit is 0. A written 1 leaves that bit unchanged.
- R5: When a hardware set and a software clear hit the same flag bit in the same cycle, the bit ends up set.
- R6: The request, registered one cycle after its inputs, equals the control bit 0 (global enable) ANDed with the OR of (flag AND enable) over all lines.
- R7: The wake output is combinational: the OR over lines of enable bit AND (raw pin XNOR polarity bit). It does not depend on the global enable and it responds with the clock stopped.
- R8: Register map: address 0 is polarity, 1 is enable, 2 is flags, and 3 holds the global enable in bit 0 with bits 7..1 reading 0. The read data is registered and shows the register addressed at the previous rising edge, with its value before that edge's update.
- R9: A line whose enable bit is 0 affects neither the request nor the wake output, even when its flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| kbd_pins | input | 8 | Raw keyboard input lines |
| irq_o | output | 1 | Combined keyboard interrupt request |
| wake_o | output | 1 | Combinational wake-up request |

## Verification
The block is driven with pins idling high and single lines pulled low, which exercises the active-low polarity. A line is also driven high under an active-high polarity, which shows that a pin value counts only through its own polarity bit. Flags are raised on masked lines and then on enabled lines, with the global enable off and then on, which separates latching from request gating. A flag is cleared both while its pin is held active and after release, to tell set-wins from a plain clear. The wake output is tested with the clock halted, using an enabled line and a masked one.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_POL  = 2'd0,
    REG_MASK = 2'd1,
    REG_FLAG = 2'd2,
    REG_CTRL = 2'd3
  } kbd_reg_e;
endpackage

// File: rtl/kbd_sync.sv
module kbd_sync #(
  parameter int N_LINES = 8,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] din,
  output logic [N_LINES-1:0] dout
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '1;
      else     sh <= {sh[STAGES-2:0], din[g]};
    end
    assign dout[g] = sh[STAGES-1];
  end
endmodule

// File: rtl/kbd_regs.sv
module kbd_regs
  import kbd_pkg::*;
#(
  parameter int N_LINES = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [N_LINES-1:0]    wdata,
  input  logic [N_LINES-1:0]    hit_i,
  output logic [N_LINES-1:0]    pol_o,
  output logic [N_LINES-1:0]    mask_o,
  output logic [N_LINES-1:0]    flags_o,
  output logic                  gie_o,
  output logic [N_LINES-1:0]    rdata_o
);
  logic [N_LINES-1:0] flag_keep;

  // Clear-by-zero write; a hardware set is ORed in afterwards, so it wins.
  always_comb begin
    flag_keep = flags_o;
    if (we && addr == REG_FLAG) flag_keep = flags_o & wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_o   <= '0;
      mask_o  <= '0;
      flags_o <= '0;
      gie_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      flags_o <= flag_keep | hit_i;
      if (we && addr == REG_POL)  pol_o  <= wdata;
      if (we && addr == REG_MASK) mask_o <= wdata;
      if (we && addr == REG_CTRL) gie_o  <= wdata[0];
      case (kbd_reg_e'(addr))
        REG_POL:  rdata_o <= pol_o;
        REG_MASK: rdata_o <= mask_o;
        REG_FLAG: rdata_o <= flags_o;
        default:  rdata_o <= {{(N_LINES-1){1'b0}}, gie_o};
      endcase
    end
  end

  // R2 / R5: every line at its active level is set after the edge, write or not.
  a_r5_hit_sets_flag: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_o & $past(hit_i)) == $past(hit_i)));

  // R4: a flag can only rise because its line was active.
  a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(hit_i)) == '0));

  // R8: control register reads only bit 0.
  a_r8_ctrl_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (addr == REG_CTRL) |=> (rdata_o[N_LINES-1:1] == '0));
endmodule

// File: rtl/kbd_irq_combine.sv
module kbd_irq_combine #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] flags_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic [N_LINES-1:0] pol_i,
  input  logic               gie_i,
  input  logic [N_LINES-1:0] pins_i,
  output logic               irq_o,
  output logic               wake_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= gie_i & |(flags_i & mask_i);
  end

  // No clock on this path: it must work in power-down.
  assign wake_o = |(mask_i & ~(pins_i ^ pol_i));

  // R6: global enable off keeps the request low.
  a_r6_gie_gates: assert property (@(posedge clk) disable iff (rst)
    !gie_i |=> !irq_o);

  // R9: no enabled flag means no request.
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    ((flags_i & mask_i) == '0) |=> !irq_o);

  // R7: with no line enabled there is no wake.
  always_comb begin
    if (mask_i == '0) a_r7_wake_needs_enable: assert (!wake_o);
  end
endmodule

// File: rtl/kbd_level_irq.sv
module kbd_level_irq
  import kbd_pkg::*;
#(
  parameter int N_LINES     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_we,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [N_LINES-1:0]    bus_wdata,
  output logic [N_LINES-1:0]    bus_rdata,
  input  logic [N_LINES-1:0]    kbd_pins,
  output logic                  irq_o,
  output logic                  wake_o
);
  logic [N_LINES-1:0] pins_s, pol, mask, flags, hit;
  logic               gie;

  kbd_sync #(.N_LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(kbd_pins), .dout(pins_s)
  );

  assign hit = ~(pins_s ^ pol);

  kbd_regs #(.N_LINES(N_LINES)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .hit_i(hit), .pol_o(pol), .mask_o(mask), .flags_o(flags), .gie_o(gie),
    .rdata_o(bus_rdata)
  );

  kbd_irq_combine #(.N_LINES(N_LINES)) u_comb (
    .clk(clk), .rst(rst), .flags_i(flags), .mask_i(mask), .pol_i(pol),
    .gie_i(gie), .pins_i(kbd_pins), .irq_o(irq_o), .wake_o(wake_o)
  );

  // R1: request stays low the cycle after reset.
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !irq_o);
endmodule

// File: tb/test_kbd_level_irq.sv
module test_kbd_level_irq;
  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] kbd_pins = 8'hFF;
  logic       irq_o, wake_o;

  int n_chk = 0, n_fail = 0;
  bit started = 0, done = 0;

  always #2 if (clk_run) clk = ~clk;

  kbd_level_irq i_kbd_level_irq (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kbd_pins(kbd_pins),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  // Behavioural reference model
  logic [7:0] m_s1, m_s2, m_pol, m_mask, m_flag, m_rd;
  logic       m_gie, m_irq;

  always @(posedge clk) begin
    logic [7:0] nf;
    if (rst) begin
      m_s1 = 8'hFF; m_s2 = 8'hFF; m_pol = 0; m_mask = 0; m_flag = 0;
      m_gie = 0; m_irq = 0; m_rd = 0;
    end else begin
      case (bus_addr)
        2'd0: m_rd = m_pol;
        2'd1: m_rd = m_mask;
        2'd2: m_rd = m_flag;
        default: m_rd = {7'b0, m_gie};
      endcase
      m_irq = m_gie && ((m_flag & m_mask) != 0);
      nf = m_flag;
      if (bus_we && bus_addr == 2'd2) nf = nf & bus_wdata;
      for (int i = 0; i < 8; i++) if (m_s2[i] == m_pol[i]) nf[i] = 1'b1;
      m_flag = nf;
      m_s2 = m_s1;
      m_s1 = kbd_pins;
      if (bus_we && bus_addr == 2'd0) m_pol = bus_wdata;
      if (bus_we && bus_addr == 2'd1) m_mask = bus_wdata;
      if (bus_we && bus_addr == 2'd3) m_gie = bus_wdata[0];
    end
    started = 1;
  end

  function automatic logic model_wake();
    logic w = 0;
    for (int i = 0; i < 8; i++)
      if (m_mask[i] && (kbd_pins[i] == m_pol[i])) w = 1;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) if (started && !done) begin
    chk("R6 irq", {7'b0, irq_o}, {7'b0, m_irq});
    chk("R8 rdata", bus_rdata, m_rd);
    chk("R7 wake", {7'b0, wake_o}, {7'b0, model_wake()});
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_we = 0; bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    idle(3);
    rst = 0;
    // R1: reset state
    chk("R1 irq", {7'b0, irq_o}, 8'h00);
    for (int a = 0; a < 4; a++) begin rd(a[1:0], v); chk("R1 reg", v, 8'h00); end

    // R2 timing + R3: masked line 3 pulled low still latches
    @(negedge clk); kbd_pins[3] = 0;
    idle(1); rd(2'd2, v); chk("R2 not yet", v, 8'h00);
    rd(2'd2, v); chk("R3 latched masked", v, 8'h08);
    chk("R9 masked irq", {7'b0, irq_o}, 8'h00);
    chk("R9 masked wake", {7'b0, wake_o}, 8'h00);

    // R5: clear while still active -> stays set
    wr(2'd2, 8'h00); rd(2'd2, v); chk("R5 set wins", v, 8'h08);
    // R4: release then clear; writing 1 keeps bits
    @(negedge clk); kbd_pins[3] = 1; idle(3);
    wr(2'd2, 8'hFF); rd(2'd2, v); chk("R4 write one keeps", v, 8'h08);
    wr(2'd2, 8'hF7); rd(2'd2, v); chk("R4 clear", v, 8'h00);

    // R2: active-high line 4
    wr(2'd0, 8'h10); idle(3);
    rd(2'd2, v); chk("R2 pol high idle-high pin", v, 8'h10);
    @(negedge clk); kbd_pins[4] = 0; idle(3);
    wr(2'd2, 8'h00); rd(2'd2, v); chk("R2 pol high low pin clears", v, 8'h00);
    wr(2'd0, 8'h00);

    // R6: global enable gating
    wr(2'd1, 8'h20); @(negedge clk); kbd_pins[5] = 0; idle(4);
    chk("R6 gie off", {7'b0, irq_o}, 8'h00);
    wr(2'd3, 8'hFF); idle(1);
    chk("R6 gie on", {7'b0, irq_o}, 8'h01);
    rd(2'd3, v); chk("R8 ctrl read", v, 8'h01);
    rd(2'd1, v); chk("R8 mask read", v, 8'h20);
    @(negedge clk); kbd_pins[5] = 1; idle(3);
    wr(2'd2, 8'h00); idle(1);
    chk("R6 cleared", {7'b0, irq_o}, 8'h00);

    // R7: wake with clock stopped
    @(negedge clk); clk_run = 0; #1;
    kbd_pins[5] = 0; #3;
    chk("R7 wake no clock", {7'b0, wake_o}, 8'h01);
    kbd_pins[5] = 1; #3;
    chk("R7 wake drop", {7'b0, wake_o}, 8'h00);
    kbd_pins[6] = 0; #3;
    chk("R9 masked no wake", {7'b0, wake_o}, 8'h00);
    kbd_pins[6] = 1; #3;
    clk_run = 1;
    idle(4);
    wr(2'd3, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    idle(3);
    finish_run();
  end
endmodule